// File: doc/BRIEF.md
# Interrupt Interval Timer with Buffered Reload

This block is one interval-timer channel behind a small word-addressed register bank. Software writes a period into a staging register, commits it to the active reload register with a control-word command, and then starts the channel with a second command. The counter then steps down once per pulse on a single-cycle tick-enable input. When it runs out, the channel raises a one-clock interrupt pulse. It then either reloads and keeps running or stops, depending on a control bit.

The bank has 17 words of 32 bits each. The word index is taken from address bits [6:2]. Word 2 is the control word, word 15 is the reload staging word, and word 16 returns the live count. Every other word is plain storage that reads back what was last written. Those words configure neighbouring functions that this block does not implement. Writes are byte-qualified. Reads return data one clock after the request.

Top module: `itmr_top`

## Requirements
- R1: After a synchronous reset, every register word, the active reload value and the live count are zero, and `irq` is low.
- R2: A write to any index in 0..15 other than 2 and 15 replaces only the bytes whose `wstrb` bit is set, and a later read returns the merged word. Indices 17..31 store nothing and read as zero.
- R3: Writing word 2 with bit 21 set copies word 15 into the active reload value. That write changes neither the running state nor the count.
- R4: Writing word 2 with bit 21 clear and bit 20 set loads the count from the active reload value (not from word 15) and starts counting.
- R5: While running, each cycle with `tick_en` high lowers the count by one, and cycles without it leave the count unchanged. Reading word 16 returns the live count, has no side effect, and writes to word 16 are dropped.
- R6: `irq` is high for exactly the one cycle after a tick that takes the count from 1 to 0, and is low in every cycle not following such an expiring tick.
- R7: On expiry with word 2 bit 22 set, the count reloads from the active reload value and keeps running. With bit 22 clear, the count stays at 0, counting stops, and later ticks raise no interrupt.
- R8: In a cycle where word 2 is written, a coincident tick is discarded; the write's effect alone determines the next count.
- R9: A start with an active reload value of 0 expires on the first tick. With bit 22 set, it expires on every tick.
- R10: `rdata` is registered. It shows the addressed word in the cycle after `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W (7) | Byte address; bits [6:2] select the word |
| wdata | input | DATA_W (32) | Write data |
| wstrb | input | DATA_W/8 (4) | Per-byte write enables |
| rdata | output | DATA_W (32) | Registered read data |
| tick_en | input | 1 | One-cycle count pulse |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
A control-word write and a count tick can land on the same clock edge. In that case the write must win and the tick must vanish. The bench provokes this by raising `tick_en` in the very cycle of a restart command and again in the cycle of a commit command, with the counter running mid-period. It then judges the outcome by reading word 16 and by confirming that no interrupt appears. A restart must show the full reload value, and a commit must show the count exactly as it was before that cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned REG_WORDS  = 17;
  localparam int unsigned CTRL_IDX   = 2;
  localparam int unsigned STAGE_IDX  = 15;
  localparam int unsigned LIVE_IDX   = 16;
  localparam int unsigned BIT_RUN    = 20;
  localparam int unsigned BIT_COMMIT = 21;
  localparam int unsigned BIT_REPEAT = 22;
endpackage

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic [DATA_W-1:0]   rword,
  output logic [DATA_W-1:0]   stage_word,
  output logic                repeat_bit,
  output logic                cmd_commit,
  output logic                cmd_run
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] mem [REG_WORDS];
  logic [DATA_W-1:0] cur, merged;
  logic              in_range, wr_ok;

  assign in_range = (idx < IDX_W'(REG_WORDS));
  assign wr_ok    = we && in_range && (idx != IDX_W'(LIVE_IDX));
  assign cur      = in_range ? mem[idx] : '0;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = wstrb[b] ? wdata[b*8 +: 8] : cur[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_WORDS; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[idx] <= merged;
    end
  end

  assign rword      = cur;
  assign stage_word = mem[STAGE_IDX];
  assign repeat_bit = mem[CTRL_IDX][BIT_REPEAT];
  assign cmd_commit = merged[BIT_COMMIT];
  assign cmd_run    = merged[BIT_RUN];

  // R2: a full-strobe control write is visible on the next cycle
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (rst)
    (we && idx == IDX_W'(CTRL_IDX) && &wstrb) |=> repeat_bit == $past(wdata[BIT_REPEAT]));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             hold,
  input  logic             commit,
  input  logic             start,
  input  logic             repeat_en,
  input  logic [CNT_W-1:0] stage_val,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] reload_q, count_q;
  logic             run_q, irq_q, step, expire;

  assign step   = tick && run_q && !hold;
  assign expire = step && (count_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= expire;
      if (commit) reload_q <= stage_val;
      if (start) begin
        count_q <= reload_q;
        run_q   <= 1'b1;
      end else if (expire) begin
        if (repeat_en) begin
          count_q <= reload_q;
        end else begin
          count_q <= '0;
          run_q   <= 1'b0;
        end
      end else if (step) begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assign count = count_q;
  assign irq   = irq_q;

  p_commit_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (commit && !start) |=> (count_q == $past(count_q)) && (run_q == $past(run_q)));
  p_start_load_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> run_q && (count_q == $past(reload_q)));
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (step && count_q > CNT_W'(1)) |=> count_q == $past(count_q) - CNT_W'(1));
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(tick) && $past(run_q));
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && !repeat_en) |=> !run_q && count_q == '0);
  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (hold && tick) |=> !irq_q);
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic [DATA_W-1:0]   rdata,
  input  logic                tick_en,
  output logic                irq
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              addr_unused;
  logic [DATA_W-1:0] rword, stage_word, rdata_q;
  logic [CNT_W-1:0]  count;
  logic              repeat_bit, cmd_commit, cmd_run, ctl_wr, commit, start;

  assign idx         = addr[ADDR_W-1:2];
  assign addr_unused = ^addr[1:0];
  assign ctl_wr      = wr_en && (idx == IDX_W'(CTRL_IDX));
  assign commit      = ctl_wr && cmd_commit;
  assign start       = ctl_wr && !cmd_commit && cmd_run;

  itmr_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .idx(idx), .wdata(wdata), .wstrb(wstrb),
    .rword(rword), .stage_word(stage_word), .repeat_bit(repeat_bit),
    .cmd_commit(cmd_commit), .cmd_run(cmd_run)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .hold(ctl_wr), .commit(commit),
    .start(start), .repeat_en(repeat_bit), .stage_val(stage_word[CNT_W-1:0]),
    .count(count), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= (idx == IDX_W'(LIVE_IDX)) ? DATA_W'(count) : rword;
    end
  end

  assign rdata = rdata_q;

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !irq && rdata_q == '0);
endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [31:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] rd_exp[$];
  string       rd_tag[$];
  logic        irq_exp[$];
  string       irq_tag[$];
  logic        pend_rd = 1'b0, pend_tk = 1'b0;
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  itmr_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    pend_rd <= rd_en && !rst;
    pend_tk <= tick_en && !rst;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pend_rd && rd_exp.size() > 0) check(rdata, rd_exp.pop_front(), rd_tag.pop_front());
      if (pend_tk && irq_exp.size() > 0) check({31'b0, irq}, {31'b0, irq_exp.pop_front()}, irq_tag.pop_front());
      else if (!pend_tk) check({31'b0, irq}, 32'b0, "R6 idle");
    end
  end

  // driver
  task automatic do_write(input int idx, input logic [31:0] d, input logic [3:0] s,
                          input bit tk, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(idx * 4); wdata = d; wstrb = s; tick_en = tk;
    if (tk) begin irq_exp.push_back(1'b0); irq_tag.push_back(tag); end
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic do_read(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'(idx * 4);
    rd_exp.push_back(exp); rd_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    last_rd = exp;
  endtask

  task automatic do_tick(input logic exp_irq, input string tag);
    @(negedge clk);
    tick_en = 1'b1;
    irq_exp.push_back(exp_irq); irq_tag.push_back(tag);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    do_read(2, 32'h0, "R1 ctrl");
    do_read(15, 32'h0, "R1 stage");
    do_read(16, 32'h0, "R1 live");
    // R2: plain storage with byte enables, out-of-range index
    do_write(0, 32'h1234_5678, 4'hF, 0, "R2");
    do_read(0, 32'h1234_5678, "R2 full");
    do_write(0, 32'hAABB_CCDD, 4'b0010, 0, "R2");
    do_read(0, 32'h1234_CC78, "R2 strobe");
    do_write(20, 32'h5, 4'hF, 0, "R2");
    do_read(20, 32'h0, "R2 range");
    // R3: commit does not start
    do_write(15, 32'd5, 4'hF, 0, "R3");
    do_write(2, 32'h0020_0000, 4'hF, 0, "R3");
    do_tick(1'b0, "R3 tick");
    do_tick(1'b0, "R3 tick");
    do_read(16, 32'h0, "R3 idle count");
    // R4: start uses active reload, not stage
    do_write(15, 32'd9, 4'hF, 0, "R4");
    do_write(2, 32'h0010_0000, 4'hF, 0, "R4");
    do_read(16, 32'd5, "R4 load");
    do_read(16, 32'd5, "R5 read no side effect");
    // R5: step per tick only
    do_tick(1'b0, "R5");
    repeat (3) @(negedge clk);
    do_read(16, 32'd4, "R5 step");
    // R10: hold
    repeat (2) @(negedge clk);
    check(rdata, last_rd, "R10 hold");
    do_tick(1'b0, "R5"); do_tick(1'b0, "R5"); do_tick(1'b0, "R5");
    do_read(16, 32'd1, "R5 count");
    do_tick(1'b1, "R6 expire");
    do_read(16, 32'd0, "R7 oneshot count");
    do_tick(1'b0, "R7 stopped");
    do_read(16, 32'd0, "R7 stopped count");
    // R7: repeat mode
    do_write(2, 32'h0060_0000, 4'hF, 0, "R7");
    do_write(2, 32'h0050_0000, 4'hF, 0, "R7");
    do_read(2, 32'h0050_0000, "R2 ctrl readback");
    for (int i = 0; i < 9; i++) do_tick(i == 8, "R7 period1");
    do_read(16, 32'd9, "R7 reload");
    for (int i = 0; i < 9; i++) do_tick(i == 8, "R7 period2");
    // R8: write beats tick
    do_tick(1'b0, "R8"); do_tick(1'b0, "R8"); do_tick(1'b0, "R8");
    do_read(16, 32'd6, "R8 pre");
    do_write(2, 32'h0050_0000, 4'hF, 1, "R8 restart+tick");
    do_read(16, 32'd9, "R8 restart");
    do_write(2, 32'h0060_0000, 4'hF, 1, "R8 commit+tick");
    do_read(16, 32'd9, "R8 commit");
    do_tick(1'b0, "R8 post");
    do_read(16, 32'd8, "R8 running");
    // R9: zero reload
    do_write(15, 32'd0, 4'hF, 0, "R9");
    do_write(2, 32'h0020_0000, 4'hF, 0, "R9");
    do_tick(1'b0, "R9 still running");
    do_read(16, 32'd7, "R3 commit kept count");
    do_write(2, 32'h0010_0000, 4'hF, 0, "R9");
    do_tick(1'b1, "R9 first tick");
    do_tick(1'b0, "R9 stopped");
    do_write(2, 32'h0050_0000, 4'hF, 0, "R9");
    do_tick(1'b1, "R9 repeat a");
    do_tick(1'b1, "R9 repeat b");
    do_read(16, 32'd0, "R9 count");
    do_write(2, 32'h0, 4'hF, 0, "R7");
    do_tick(1'b1, "R7 last");
    do_tick(1'b0, "R7 after stop");
    // R5: write to live word dropped
    do_write(16, 32'h77, 4'hF, 0, "R5");
    do_read(16, 32'd0, "R5 live ro");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule